// File: doc/BRIEF.md
# Instruction cache with critical-first fill

This block is a read-only, set-associative instruction cache. A fetch unit presents byte addresses and receives the aligned 64-bit double word that contains each one. Every line holds 32 bytes, an address tag and a single valid bit. Nothing outside a line fill writes the arrays, and there is no snoop path. Coherence is kept by a one-cycle flash invalidate that clears every valid bit.

On a miss the cache asks memory for the line, starting with the double word that holds the missed address. Memory returns four 64-bit beats, beginning at that critical double word and wrapping around the line. The stalled fetch is released in the cycle its beat arrives. After that, fetches to the same line are forwarded once their beat has landed, and fetches that hit other lines are served while the fill continues. A second miss waits until the current fill ends.

Back-pressure works as follows. A fetch is accepted in a cycle where `fetch_valid` and `fetch_ready` are both high. While it is refused, the requester holds `fetch_valid` and `fetch_addr` steady. The response has no ready, because the fetch unit always takes it. The memory request is a valid/ready handshake in which the cache holds `mem_req_valid` and `mem_req_addr` until `mem_req_ready`. Memory beats carry no ready and are always accepted during a fill.

Top module: `icache_cf`

## Requirements
- R1: Address fields are as follows. Bits [2:0] select a byte and are ignored. Bits [4:3] pick the double word in the line. The next log2(SETS) bits give the set, and the remaining upper bits form the tag.
- R2: A fetch to a valid line is accepted in the same cycle, and in the next cycle `rsp_valid` is high with that double word on `rsp_data`.
- R3: A fetch that misses while no fill runs is refused. The cache raises one memory request whose address is the line base with bits [4:3] equal to the missed double word and bits [2:0] zero. The request stays stable until accepted.
- R4: The four beats of a fill are taken as double words crit, crit+1, crit+2 and crit+3, modulo 4, and each is stored in its place in the line.
- R5: The missed fetch is accepted in the cycle its critical beat arrives, and its response carries that beat's data.
- R6: A fetch to the line being filled is accepted once its double word has arrived, including the arrival cycle. Until then it is refused.
- R7: A fetch that hits a different valid line is accepted with no wait while a fill is in progress.
- R8: A miss to another line during a fill is refused until the fill ends. Only one fill is outstanding at a time.
- R9: A line becomes valid after its fourth beat, and then all four double words hit with no memory traffic.
- R10: The victim is the lowest-numbered invalid way of the set. If the set is full, a round-robin pointer shared by all sets picks the victim. The pointer starts at way 0 after reset and advances by one whenever a valid line is replaced.
- R11: A cycle with `flash_inval` high clears every valid bit, and no fetch is accepted in that cycle. Earlier hits then miss.
- R12: An invalidate during a fill lets memory finish its four beats. Those beats are discarded: the line is not made valid, nothing is forwarded from it, and a fetch to it stalls and then issues a fresh request.
- R13: After reset no line is valid, `rsp_valid` is low and `mem_req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flash_inval | input | 1 | One-cycle pulse that invalidates every line |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Fetch accepted this cycle |
| fetch_addr | input | ADDR_W | Fetch byte address |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_data | output | DATA_W | Double word holding the fetched address |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_ready | input | 1 | Memory accepts the line request |
| mem_req_addr | output | ADDR_W | Line base with the critical double word in bits [4:3] |
| mem_beat_valid | input | 1 | A fill beat is present |
| mem_beat_data | input | DATA_W | Fill beat data |

## Verification
The bench builds the cache with four sets, two ways and a 16-bit address. In that configuration every line of the cache can be filled, and each of the four critical positions is used as a fill start. Every double word of every line is then read back. Full sets are cheap to reach, so both the invalid-way choice and the round-robin eviction can be checked against a pointer the bench tracks itself. Adjustable beat gaps and request delays open wide fill windows, and inside those windows the bench checks forwarding, hits under a fill, stalled second misses and an invalidate that lands in the middle of a fill.

// File: rtl/icache_cf_pkg.sv
package icache_cf_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_FILL = 2'd2
  } fill_st_e;
endpackage

// File: rtl/icache_tag_array.sv
module icache_tag_array #(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flash_clr,
  input  logic [$clog2(SETS)-1:0]   lk_idx,
  input  logic [TAG_W-1:0]          lk_tag,
  output logic [WAYS-1:0]           hit_vec,
  output logic [WAYS-1:0]           row_vld,
  input  logic                      alloc,
  input  logic                      commit,
  input  logic [$clog2(SETS)-1:0]   wr_idx,
  input  logic [$clog2(WAYS)-1:0]   wr_way,
  input  logic [TAG_W-1:0]          wr_tag
);
  logic [WAYS-1:0]  vld  [SETS];
  logic [TAG_W-1:0] tags [SETS][WAYS];

  // valid bits: flash clear wins over any fill update
  always_ff @(posedge clk) begin
    if (!rst_n || flash_clr) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else begin
      if (alloc)  vld[wr_idx][wr_way] <= 1'b0;
      if (commit) vld[wr_idx][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) tags[wr_idx][wr_way] <= wr_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign row_vld[w] = vld[lk_idx][w];
    assign hit_vec[w] = vld[lk_idx][w] && (tags[lk_idx][w] == lk_tag);
  end
endmodule

// File: rtl/icache_data_array.sv
module icache_data_array #(
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  parameter int BEATS  = 4,
  parameter int DATA_W = 64
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [$clog2(SETS)-1:0]    wr_idx,
  input  logic [$clog2(WAYS)-1:0]    wr_way,
  input  logic [$clog2(BEATS)-1:0]   wr_dw,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [$clog2(SETS)-1:0]    rd_idx,
  input  logic [$clog2(WAYS)-1:0]    rd_way,
  input  logic [$clog2(BEATS)-1:0]   rd_dw,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int DEPTH = SETS * WAYS * BEATS;
  localparam int AW    = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wa, ra;

  assign wa = {wr_idx, wr_way, wr_dw};
  assign ra = {rd_idx, rd_way, rd_dw};

  always_ff @(posedge clk) begin
    if (wr_en) mem[wa] <= wr_data;
  end

  assign rd_data = mem[ra];
endmodule

// File: rtl/icache_fill_ctl.sv
module icache_fill_ctl
  import icache_cf_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int BEATS = 4,
  parameter int TAG_W = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flash_clr,
  input  logic                       start,
  input  logic [$clog2(SETS)-1:0]    miss_idx,
  input  logic [TAG_W-1:0]           miss_tag,
  input  logic [$clog2(BEATS)-1:0]   miss_dw,
  input  logic [WAYS-1:0]            row_vld,
  output logic [$clog2(WAYS)-1:0]    victim,
  output logic                       req_valid,
  input  logic                       req_ready,
  input  logic                       beat_valid,
  output logic                       busy,
  output logic                       discard,
  output logic [$clog2(SETS)-1:0]    fill_idx,
  output logic [TAG_W-1:0]           fill_tag,
  output logic [$clog2(WAYS)-1:0]    fill_way,
  output logic [$clog2(BEATS)-1:0]   crit_dw,
  output logic [$clog2(BEATS)-1:0]   beat_dw,
  output logic [BEATS-1:0]           arrived,
  output logic                       beat_wr,
  output logic                       commit
);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int BEAT_W = $clog2(BEATS);

  fill_st_e          st;
  logic [BEAT_W-1:0] cnt;
  logic [WAY_W-1:0]  rr;
  logic              found;
  logic              last;

  always_comb begin
    victim = rr;
    found  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !row_vld[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
  end

  assign busy      = (st != FS_IDLE);
  assign req_valid = (st == FS_REQ);
  assign beat_dw   = crit_dw + cnt;
  assign beat_wr   = (st == FS_FILL) && beat_valid;
  assign last      = (cnt == BEAT_W'(BEATS - 1));
  assign commit    = beat_wr && last && !discard && !flash_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= FS_IDLE;
      cnt     <= '0;
      rr      <= '0;
      arrived <= '0;
      discard <= 1'b0;
      fill_idx <= '0;
      fill_tag <= '0;
      fill_way <= '0;
      crit_dw  <= '0;
    end else begin
      case (st)
        FS_IDLE: if (start) begin
          st       <= FS_REQ;
          fill_idx <= miss_idx;
          fill_tag <= miss_tag;
          fill_way <= victim;
          crit_dw  <= miss_dw;
          cnt      <= '0;
          arrived  <= '0;
          discard  <= 1'b0;
          if (&row_vld) rr <= (rr == WAY_W'(WAYS - 1)) ? '0 : rr + 1'b1;
        end
        FS_REQ: begin
          if (flash_clr) discard <= 1'b1;
          if (req_ready) st <= FS_FILL;
        end
        FS_FILL: begin
          if (flash_clr) discard <= 1'b1;
          if (beat_valid) begin
            arrived[beat_dw] <= 1'b1;
            cnt <= cnt + 1'b1;
            if (last) st <= FS_IDLE;
          end
        end
        default: st <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/icache_cf.sv
module icache_cf #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 32,
  parameter int DATA_W     = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flash_inval,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_beat_valid,
  input  logic [DATA_W-1:0] mem_beat_data
);
  localparam int BEATS  = LINE_BYTES * 8 / DATA_W;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  logic [BEAT_W-1:0] f_dw;
  logic [IDX_W-1:0]  f_idx;
  logic [TAG_W-1:0]  f_tag;
  logic              unused_byte_sel;

  assign f_dw  = fetch_addr[OFF_W-1:BYTE_W];
  assign f_idx = fetch_addr[OFF_W+IDX_W-1:OFF_W];
  assign f_tag = fetch_addr[ADDR_W-1:OFF_W+IDX_W];
  assign unused_byte_sel = ^fetch_addr[BYTE_W-1:0];

  logic [WAYS-1:0]   hit_vec, row_vld;
  logic [WAY_W-1:0]  hit_way, victim, fill_way, rd_way;
  logic [IDX_W-1:0]  fill_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic [BEAT_W-1:0] crit_dw, beat_dw;
  logic [BEATS-1:0]  arrived;
  logic              busy, discard, beat_wr, commit, start;
  logic              any_hit, in_fill, beat_now;
  logic [DATA_W-1:0] rd_data, sel_data;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign any_hit  = |hit_vec;
  assign in_fill  = busy && !discard && (f_idx == fill_idx) && (f_tag == fill_tag);
  assign beat_now = beat_wr && (beat_dw == f_dw);
  assign fetch_ready = !flash_inval && (any_hit || (in_fill && (arrived[f_dw] || beat_now)));
  assign start    = fetch_valid && !busy && !flash_inval && !any_hit;
  assign rd_way   = in_fill ? fill_way : hit_way;
  assign sel_data = (in_fill && beat_now) ? mem_beat_data : rd_data;
  assign mem_req_addr = {fill_tag, fill_idx, crit_dw, {BYTE_W{1'b0}}};

  icache_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .flash_clr(flash_inval),
    .lk_idx(f_idx), .lk_tag(f_tag), .hit_vec(hit_vec), .row_vld(row_vld),
    .alloc(start), .commit(commit),
    .wr_idx(start ? f_idx : fill_idx), .wr_way(start ? victim : fill_way),
    .wr_tag(f_tag)
  );

  icache_data_array #(.SETS(SETS), .WAYS(WAYS), .BEATS(BEATS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .wr_en(beat_wr), .wr_idx(fill_idx), .wr_way(fill_way),
    .wr_dw(beat_dw), .wr_data(mem_beat_data),
    .rd_idx(f_idx), .rd_way(rd_way), .rd_dw(f_dw), .rd_data(rd_data)
  );

  icache_fill_ctl #(.SETS(SETS), .WAYS(WAYS), .BEATS(BEATS), .TAG_W(TAG_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .flash_clr(flash_inval), .start(start),
    .miss_idx(f_idx), .miss_tag(f_tag), .miss_dw(f_dw), .row_vld(row_vld),
    .victim(victim), .req_valid(mem_req_valid), .req_ready(mem_req_ready),
    .beat_valid(mem_beat_valid), .busy(busy), .discard(discard),
    .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_way(fill_way),
    .crit_dw(crit_dw), .beat_dw(beat_dw), .arrived(arrived),
    .beat_wr(beat_wr), .commit(commit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= fetch_valid && fetch_ready;
      if (fetch_valid && fetch_ready) rsp_data <= sel_data;
    end
  end
endmodule

// File: rtl/icache_cf_chk.sv
module icache_cf_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int DATA_W     = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flash_inval,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_beat_valid
);
  localparam int BEATS  = LINE_BYTES * 8 / DATA_W;
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int CNT_W  = $clog2(BEATS + 1);

  logic [CNT_W-1:0] outst;

  always_ff @(posedge clk) begin
    if (!rst_n) outst <= '0;
    else if (mem_req_valid && mem_req_ready) outst <= CNT_W'(BEATS);
    else if (mem_beat_valid && outst != '0) outst <= outst - 1'b1;
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_miss_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(fetch_valid && !fetch_ready)
      && mem_req_addr[OFF_W-1:BYTE_W] == $past(fetch_addr[OFF_W-1:BYTE_W])
      && mem_req_addr[BYTE_W-1:0] == '0);

  p_single_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> outst == '0);

  p_inval_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flash_inval |-> !fetch_ready);

  p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready |=> rsp_valid);
endmodule

bind icache_cf icache_cf_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flash_inval(flash_inval),
  .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
  .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_beat_valid(mem_beat_valid)
);

// File: tb/tb_icache_cf.sv
module tb_icache_cf;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flash_inval = 1'b0;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [15:0] fetch_addr = '0;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic        mem_beat_valid = 1'b0;
  logic [63:0] mem_beat_data = '0;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  int req_delay = 1;
  int beat_gap = 1;
  logic [15:0] last_req = '0;

  always #2.5 clk = ~clk;

  icache_cf #(.ADDR_W(16), .SETS(4), .WAYS(2), .LINE_BYTES(32), .DATA_W(64)) dut (
    .clk(clk), .rst_n(rst_n), .flash_inval(flash_inval),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_beat_valid(mem_beat_valid),
    .mem_beat_data(mem_beat_data)
  );

  function automatic logic [63:0] mdata(input logic [15:0] a);
    logic [12:0] w;
    w = a[15:3];
    return {16'hC0DE, 3'b0, w, 16'h0F0F ^ {3'b0, w}, 3'b0, w};
  endfunction

  function automatic logic [15:0] mk(input int t, input int s, input int d, input int b);
    return 16'((t << 7) | (s << 5) | (d << 3) | b);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: accepts a request, then returns four wrapped beats
  initial forever begin
    @(negedge clk);
    if (mem_req_valid) begin
      repeat (req_delay) @(negedge clk);
      mem_req_ready = 1'b1;
      last_req = mem_req_addr;
      req_cnt++;
      @(negedge clk);
      mem_req_ready = 1'b0;
      for (int b = 0; b < 4; b++) begin
        repeat (beat_gap) @(negedge clk);
        mem_beat_valid = 1'b1;
        mem_beat_data = mdata({last_req[15:5], 2'(last_req[4:3] + 2'(b)), 3'b0});
        @(negedge clk);
        mem_beat_valid = 1'b0;
      end
    end
  end

  task automatic do_fetch(input logic [15:0] a, input string req, output int waits);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr = a;
    waits = 0;
    #1;
    while (!fetch_ready && waits < 300) begin
      @(negedge clk);
      #1;
      waits++;
    end
    chk(waits < 300, req, 64'(waits), 64'd300);
    @(posedge clk);
    #1;
    fetch_valid = 1'b0;
    chk(rsp_valid == 1'b1, req, 64'(rsp_valid), 64'd1);
    chk(rsp_data == mdata(a), req, rsp_data, mdata(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w;
    int prev;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R13", 64'(rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R13", 64'(mem_req_valid), 0);
    rst_n = 1'b1;

    // R3 R4 R5: fill every line, each set starting at a different double word
    for (int t = 0; t < 2; t++) begin
      for (int s = 0; s < 4; s++) begin
        int d;
        d = (t + s) % 4;
        prev = req_cnt;
        do_fetch(mk(t, s, d, s), "R5", w);
        chk(req_cnt == prev + 1, "R3", 64'(req_cnt), 64'(prev + 1));
        chk(last_req == mk(t, s, d, 0), "R3", 64'(last_req), 64'(mk(t, s, d, 0)));
        chk(w > 0, "R5 stall before critical beat", 64'(w), 64'd1);
      end
    end
    repeat (20) @(negedge clk);

    // R1 R2 R4 R9: every double word of every line hits with no memory traffic
    prev = req_cnt;
    for (int t = 0; t < 2; t++)
      for (int s = 0; s < 4; s++)
        for (int d = 0; d < 4; d++) begin
          do_fetch(mk(t, s, d, (t * 4 + s + d) % 8), "R1 R2 R4", w);
          chk(w == 0, "R2", 64'(w), 0);
        end
    chk(req_cnt == prev, "R9", 64'(req_cnt), 64'(prev));

    // R10: full set uses round-robin pointer starting at way 0
    do_fetch(mk(2, 0, 0, 0), "R10", w);
    repeat (20) @(negedge clk);
    prev = req_cnt;
    do_fetch(mk(1, 0, 1, 0), "R10", w);
    chk(req_cnt == prev && w == 0, "R10 tag1 kept", 64'(req_cnt - prev), 0);
    do_fetch(mk(0, 0, 1, 0), "R10", w);
    chk(req_cnt == prev + 1, "R10 tag0 evicted", 64'(req_cnt), 64'(prev + 1));
    repeat (20) @(negedge clk);
    prev = req_cnt;
    do_fetch(mk(2, 0, 3, 0), "R10", w);
    do_fetch(mk(0, 0, 2, 0), "R10", w);
    chk(req_cnt == prev, "R10 second victim is way 1", 64'(req_cnt), 64'(prev));

    // R6 R7 R8: activity inside a slow fill
    beat_gap = 4;
    req_delay = 0;
    prev = req_cnt;
    do_fetch(mk(3, 1, 2, 0), "R5", w);
    chk(req_cnt == prev + 1, "R3", 64'(req_cnt), 64'(prev + 1));
    do_fetch(mk(1, 2, 0, 0), "R7", w);
    chk(w == 0, "R7 hit under fill", 64'(w), 0);
    do_fetch(mk(3, 1, 3, 0), "R6", w);
    do_fetch(mk(3, 1, 2, 4), "R6", w);
    chk(w == 0, "R6 arrived word forwarded", 64'(w), 0);
    prev = req_cnt;
    do_fetch(mk(2, 3, 0, 0), "R8", w);
    chk(w >= 4, "R8 second miss stalls", 64'(w), 64'd4);
    chk(req_cnt == prev + 1, "R8", 64'(req_cnt), 64'(prev + 1));
    repeat (30) @(negedge clk);
    prev = req_cnt;
    do_fetch(mk(3, 1, 0, 0), "R9", w);
    chk(w == 0, "R9", 64'(w), 0);
    do_fetch(mk(3, 1, 1, 0), "R9", w);
    chk(w == 0 && req_cnt == prev, "R9", 64'(w), 0);

    // R11: flash invalidate blocks the cycle and clears the lines
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr = mk(1, 2, 0, 0);
    flash_inval = 1'b1;
    #1;
    chk(fetch_ready == 1'b0, "R11 no accept during invalidate", 64'(fetch_ready), 0);
    @(negedge clk);
    flash_inval = 1'b0;
    fetch_valid = 1'b0;
    prev = req_cnt;
    do_fetch(mk(1, 2, 0, 0), "R11", w);
    chk(req_cnt == prev + 1, "R11 line missed after invalidate", 64'(req_cnt), 64'(prev + 1));
    repeat (30) @(negedge clk);

    // R12: invalidate in the middle of a fill
    beat_gap = 3;
    do_fetch(mk(5, 0, 1, 0), "R5", w);
    @(negedge clk);
    flash_inval = 1'b1;
    @(negedge clk);
    flash_inval = 1'b0;
    prev = req_cnt;
    do_fetch(mk(5, 0, 3, 0), "R12", w);
    chk(req_cnt == prev + 1, "R12 fresh request after discard", 64'(req_cnt), 64'(prev + 1));
    chk(last_req == mk(5, 0, 3, 0), "R12 new critical word", 64'(last_req), 64'(mk(5, 0, 3, 0)));
    repeat (30) @(negedge clk);
    prev = req_cnt;
    do_fetch(mk(5, 0, 1, 0), "R12", w);
    chk(req_cnt == prev, "R12 refilled line valid", 64'(req_cnt), 64'(prev));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule